// File: doc/BRIEF.md
# RTC calendar core with triggered shadow commit

This block keeps wall-clock time for a register-mapped peripheral. A calendar of seconds, minutes, hours, day of month, day of week, month and year advances once for every cycle in which the one-per-second enable `tick_i` is high. A second set of seven fields holds an alarm time. On a tick that brings every compared field into agreement, the block raises a latched alarm and drives a level interrupt.

Software talks to the block over a simple synchronous port with 16-bit data and byte addresses; every register is a 16-bit word at an even address. Writes to the time, alarm, alarm-mask and interrupt-enable registers only land in staging copies. A write-trigger command starts a busy phase of `BUSY_CYC` cycles, and the staged values are applied when that phase ends. Time is read from a snapshot that a reload command refreshes. Software reloads, reads all seven fields, then reloads and re-reads seconds, and repeats if seconds went backwards. Control-register writes take effect only when the upper byte carries the unlock key.

Top module: `rtc_cal_core`

## Requirements
- R1: After reset, the seven time words (0x12 seconds, 0x14 minutes, 0x16 hours, 0x18 day of month, 0x1A day of week, 0x1C month, 0x1E year) read 0, 0, 0, 1, 1, 1, 0. Control (0x08) reads 0x0001. Alarm status (0x0A) reads 0, and `irq_o` is low.
- R2: Writes to the time words, the alarm words (0x20..0x2C, same field order), the alarm mask (0x10) and the interrupt enable (0x0C) leave the live logic unchanged until a write-trigger commits them.
- R3: Writing a value with bit 0 set to 0x42 while idle sets busy (control bit 6) for `BUSY_CYC` cycles. Staged values are applied at the edge where busy falls. A trigger write with bit 0 clear, or one made while busy, is ignored. Time is reloaded only if a time word was written since the previous trigger.
- R4: Staged writes made during a busy phase are not applied by that phase. They wait for the next trigger.
- R5: A control write with bit 5 set copies the live calendar into the snapshot. Time-word reads always return the snapshot.
- R6: A control write is accepted only when its bits 15:8 equal the unlock key (0x43); otherwise it has no effect. Control bit 0 is power enable (reset value 1), and ticks are ignored while it is 0.
- R7: Seconds and minutes wrap from 59 to 0 and hours from 23 to 0, each carrying into the next field.
- R8: The day of month wraps after 31, 30 or 28/29 days as the month requires. February has 29 days when year bits 1:0 are 00. The month wraps from 12 to 1 and the year from 127 to 0. On each day carry, the day of week steps from 7 back to 1.
- R9: With interrupt enable bit 0 set, a tick that makes all compared fields equal the alarm sets status bit 0 and the pending flag (0x36 bit 4). `irq_o` then goes high and stays high.
- R10: Alarm mask bit 4 set removes the day of week from the comparison. When it is clear, a day-of-week mismatch suppresses the alarm.
- R11: Control bit 3 (reset alarm) clears the status and drops `irq_o`. Control bit 1 (clear) clears the pending flag.
- R12: Interrupt enable bits 2 and 3 are reserved and read 0. With enable bit 0 committed as 0, a matching tick raises nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse per elapsed second |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Byte address of a 16-bit register |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid the cycle after `rd_en_i` |
| irq_o | output | 1 | Alarm interrupt, active-high level |

## Verification
Read data is registered, so a value requested in one cycle is compared one edge later, once the monitor has seen the strobe captured. A write, a reload or a control command acts at the edge that samples it. A tick updates the calendar, the alarm status and `irq_o` at that same edge, so the level on `irq_o` is checked at the falling edge that follows. A commit lands `BUSY_CYC` cycles after the trigger edge. The bench therefore probes the live state during busy to show nothing has moved yet, and only checks the committed values after waiting `BUSY_CYC + 2` cycles.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

   localparam int NFLD   = 7;
   localparam int RAW_W  = 7;
   localparam int SEC_W  = 6;
   localparam int MIN_W  = 6;
   localparam int HOUR_W = 5;
   localparam int DOM_W  = 5;
   localparam int DOW_W  = 3;
   localparam int MON_W  = 4;
   localparam int YEAR_W = 7;

   // byte addresses of the 16-bit registers
   localparam logic [7:0] A_CTRL = 8'h08;
   localparam logic [7:0] A_STA  = 8'h0A;
   localparam logic [7:0] A_IEN  = 8'h0C;
   localparam logic [7:0] A_MSK  = 8'h10;
   localparam logic [7:0] A_TC0  = 8'h12;
   localparam logic [7:0] A_AL0  = 8'h20;
   localparam logic [7:0] A_PDN  = 8'h36;
   localparam logic [7:0] A_TRG  = 8'h42;

   // control word bits
   localparam int B_PWR    = 0;
   localparam int B_CLR    = 1;
   localparam int B_RSTAL  = 3;
   localparam int B_RELOAD = 5;
   localparam int B_BUSY   = 6;
   // interrupt, mask and pending bits
   localparam int B_ALARM  = 0;
   localparam int B_DOWMSK = 4;
   localparam int B_PEND   = 4;

   typedef struct packed {
      logic [YEAR_W-1:0] year;
      logic [MON_W-1:0]  mon;
      logic [DOW_W-1:0]  dow;
      logic [DOM_W-1:0]  dom;
      logic [HOUR_W-1:0] hour;
      logic [MIN_W-1:0]  mins;
      logic [SEC_W-1:0]  sec;
   } cal_t;

   // index 0 = seconds ... index 6 = year
   typedef logic [NFLD-1:0][RAW_W-1:0] raw_t;

   localparam cal_t CAL_RST = '{year: '0, mon: MON_W'(1), dow: DOW_W'(1),
                                dom: DOM_W'(1), hour: '0, mins: '0, sec: '0};

   function automatic cal_t raw2cal(input raw_t r);
      cal_t c;
      c.sec  = r[0][SEC_W-1:0];
      c.mins = r[1][MIN_W-1:0];
      c.hour = r[2][HOUR_W-1:0];
      c.dom  = r[3][DOM_W-1:0];
      c.dow  = r[4][DOW_W-1:0];
      c.mon  = r[5][MON_W-1:0];
      c.year = r[6][YEAR_W-1:0];
      return c;
   endfunction

   function automatic logic [RAW_W-1:0] cal_fld(input cal_t c, input logic [2:0] idx);
      case (idx)
         3'd0:    return RAW_W'(c.sec);
         3'd1:    return RAW_W'(c.mins);
         3'd2:    return RAW_W'(c.hour);
         3'd3:    return RAW_W'(c.dom);
         3'd4:    return RAW_W'(c.dow);
         3'd5:    return RAW_W'(c.mon);
         default: return RAW_W'(c.year);
      endcase
   endfunction

   function automatic logic [DOM_W-1:0] month_days(input logic [MON_W-1:0] m, input logic leap);
      if (m == MON_W'(2))
         return leap ? DOM_W'(29) : DOM_W'(28);
      else if (m == MON_W'(4) || m == MON_W'(6) || m == MON_W'(9) || m == MON_W'(11))
         return DOM_W'(30);
      else
         return DOM_W'(31);
   endfunction

endpackage

// File: rtl/rtc_cal_calendar.sv
module rtc_cal_calendar
   import rtc_cal_pkg::*;
(
   input  logic clk_i,
   input  logic rst_ni,
   input  logic run_i,
   input  logic load_i,
   input  cal_t load_val_i,
   output cal_t cur_o,
   output cal_t nxt_o
);

   cal_t cur_q;
   cal_t nxt;
   logic c_min, c_hr, c_day, c_mon, c_yr, leap;

   always_comb begin
      nxt   = cur_q;
      leap  = (cur_q.year[1:0] == 2'b00);
      c_min = (cur_q.sec  >= SEC_W'(59));
      c_hr  = c_min && (cur_q.mins >= MIN_W'(59));
      c_day = c_hr  && (cur_q.hour >= HOUR_W'(23));
      c_mon = c_day && (cur_q.dom  >= month_days(cur_q.mon, leap));
      c_yr  = c_mon && (cur_q.mon  >= MON_W'(12));
      nxt.sec = c_min ? '0 : cur_q.sec + SEC_W'(1);
      if (c_min) nxt.mins = c_hr  ? '0 : cur_q.mins + MIN_W'(1);
      if (c_hr)  nxt.hour = c_day ? '0 : cur_q.hour + HOUR_W'(1);
      if (c_day) begin
         nxt.dom = c_mon ? DOM_W'(1) : cur_q.dom + DOM_W'(1);
         nxt.dow = (cur_q.dow >= DOW_W'(7)) ? DOW_W'(1) : cur_q.dow + DOW_W'(1);
      end
      if (c_mon) nxt.mon  = c_yr ? MON_W'(1) : cur_q.mon + MON_W'(1);
      if (c_yr)  nxt.year = cur_q.year + YEAR_W'(1);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      cur_q <= CAL_RST;
      else if (load_i)  cur_q <= load_val_i;
      else if (run_i)   cur_q <= nxt;
   end

   assign cur_o = cur_q;
   assign nxt_o = nxt;

   // R7
   sec_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_i && !load_i && cur_q.sec == SEC_W'(59) |=> cur_q.sec == '0);

   // R8
   dow_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_i && !load_i && cur_q.sec == SEC_W'(59) && cur_q.mins == MIN_W'(59) &&
      cur_q.hour == HOUR_W'(23) && cur_q.dow == DOW_W'(7) |=> cur_q.dow == DOW_W'(1));

endmodule

// File: rtl/rtc_cal_alarm.sv
module rtc_cal_alarm
   import rtc_cal_pkg::*;
(
   input  logic clk_i,
   input  logic rst_ni,
   input  logic run_i,
   input  logic en_i,
   input  logic dow_mask_i,
   input  cal_t alarm_i,
   input  cal_t nxt_i,
   input  logic rst_alarm_i,
   input  logic clr_pend_i,
   output logic status_o,
   output logic pend_o
);

   logic [NFLD-1:0] eq;
   logic hit, fire;
   logic status_q, pend_q;

   assign eq[0] = (alarm_i.sec  == nxt_i.sec);
   assign eq[1] = (alarm_i.mins == nxt_i.mins);
   assign eq[2] = (alarm_i.hour == nxt_i.hour);
   assign eq[3] = (alarm_i.dom  == nxt_i.dom);
   assign eq[4] = (alarm_i.dow  == nxt_i.dow) || dow_mask_i;
   assign eq[5] = (alarm_i.mon  == nxt_i.mon);
   assign eq[6] = (alarm_i.year == nxt_i.year);

   assign hit  = &eq;
   assign fire = run_i && en_i && hit;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         status_q <= 1'b0;
         pend_q   <= 1'b0;
      end else begin
         if (fire)             status_q <= 1'b1;
         else if (rst_alarm_i) status_q <= 1'b0;
         if (fire)             pend_q   <= 1'b1;
         else if (clr_pend_i)  pend_q   <= 1'b0;
      end
   end

   assign status_o = status_q;
   assign pend_o   = pend_q;

   // R9
   alarm_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(status_q) |-> $past(run_i && en_i));

   // R11
   alarm_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rst_alarm_i && !fire |=> !status_q);

   // R10
   dow_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !status_q && run_i && !dow_mask_i && alarm_i.dow != nxt_i.dow |=> !status_q);

endmodule

// File: rtl/rtc_cal_commit.sv
module rtc_cal_commit #(
   parameter int unsigned BUSY_CYC = 8
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic trig_i,
   output logic busy_o,
   output logic done_o
);

   localparam int unsigned CNT_W = (BUSY_CYC > 1) ? $clog2(BUSY_CYC) : 1;

   initial begin : prm_chk
      assert (BUSY_CYC >= 1);
   end

   logic busy_q;

   generate
      if (BUSY_CYC == 1) begin : g_one
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) busy_q <= 1'b0;
            else         busy_q <= trig_i && !busy_q;
         end
         assign done_o = busy_q;
      end else begin : g_cnt
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               busy_q <= 1'b0;
               cnt_q  <= '0;
            end else if (trig_i && !busy_q) begin
               busy_q <= 1'b1;
               cnt_q  <= CNT_W'(BUSY_CYC - 1);
            end else if (busy_q) begin
               if (cnt_q == '0) busy_q <= 1'b0;
               else             cnt_q  <= cnt_q - CNT_W'(1);
            end
         end
         assign done_o = busy_q && (cnt_q == '0);
      end
   endgenerate

   assign busy_o = busy_q;

   // R3
   busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(busy_q) |-> $past(trig_i));

   // R3
   busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_q && !done_o |=> busy_q);

endmodule

// File: rtl/rtc_cal_core.sv
module rtc_cal_core
   import rtc_cal_pkg::*;
#(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned BUSY_CYC   = 8,
   parameter logic [7:0]  UNLOCK_KEY = 8'h43
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_i,
   input  logic              wr_en_i,
   input  logic              rd_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [15:0]       wdata_i,
   output logic [15:0]       rdata_o,
   output logic              irq_o
);

   localparam int GRP_SPAN = 2 * NFLD;

   initial begin : prm_chk
      assert (ADDR_W >= 7);
   end

   // ---------------- address decode ----------------
   logic [ADDR_W-1:0] tm_off, al_off;
   logic tm_sel, al_sel, even;
   logic [2:0] tm_idx, al_idx;

   assign even   = ~addr_i[0];
   assign tm_off = addr_i - ADDR_W'(A_TC0);
   assign al_off = addr_i - ADDR_W'(A_AL0);
   assign tm_sel = even && addr_i >= ADDR_W'(A_TC0) && tm_off < ADDR_W'(GRP_SPAN);
   assign al_sel = even && addr_i >= ADDR_W'(A_AL0) && al_off < ADDR_W'(GRP_SPAN);
   assign tm_idx = tm_off[3:1];
   assign al_idx = al_off[3:1];

   logic is_ctrl, is_ien, is_msk, is_trg;
   assign is_ctrl = addr_i == ADDR_W'(A_CTRL);
   assign is_ien  = addr_i == ADDR_W'(A_IEN);
   assign is_msk  = addr_i == ADDR_W'(A_MSK);
   assign is_trg  = addr_i == ADDR_W'(A_TRG);

   logic busy, commit_done;
   logic ctrl_ok, trig_go, tm_wr, al_wr, ien_wr, msk_wr;
   logic do_reload, do_rst_alarm, do_clr;

   assign ctrl_ok      = wr_en_i && is_ctrl && (wdata_i[15:8] == UNLOCK_KEY);
   assign trig_go      = wr_en_i && is_trg && wdata_i[0] && !busy;
   assign tm_wr        = wr_en_i && tm_sel;
   assign al_wr        = wr_en_i && al_sel;
   assign ien_wr       = wr_en_i && is_ien;
   assign msk_wr       = wr_en_i && is_msk;
   assign do_reload    = ctrl_ok && wdata_i[B_RELOAD];
   assign do_rst_alarm = ctrl_ok && wdata_i[B_RSTAL];
   assign do_clr       = ctrl_ok && wdata_i[B_CLR];

   // ---------------- staging, pending and live copies ----------------
   raw_t stg_tm, stg_al, pnd_tm, pnd_al;
   logic stg_dirty, stg_ien, stg_msk;
   logic pnd_tm_vld, pnd_ien, pnd_msk;
   cal_t live_al;
   logic live_ien, live_msk;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         stg_tm    <= '0;
         stg_al    <= '0;
         stg_dirty <= 1'b0;
         stg_ien   <= 1'b0;
         stg_msk   <= 1'b0;
      end else begin
         if (tm_wr)  stg_tm[tm_idx] <= wdata_i[RAW_W-1:0];
         if (al_wr)  stg_al[al_idx] <= wdata_i[RAW_W-1:0];
         if (ien_wr) stg_ien <= wdata_i[B_ALARM];
         if (msk_wr) stg_msk <= wdata_i[B_DOWMSK];
         if (tm_wr)        stg_dirty <= 1'b1;
         else if (trig_go) stg_dirty <= 1'b0;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pnd_tm     <= '0;
         pnd_al     <= '0;
         pnd_tm_vld <= 1'b0;
         pnd_ien    <= 1'b0;
         pnd_msk    <= 1'b0;
      end else if (trig_go) begin
         pnd_tm     <= stg_tm;
         pnd_al     <= stg_al;
         pnd_tm_vld <= stg_dirty;
         pnd_ien    <= stg_ien;
         pnd_msk    <= stg_msk;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         live_al  <= raw2cal('0);
         live_ien <= 1'b0;
         live_msk <= 1'b0;
      end else if (commit_done) begin
         live_al  <= raw2cal(pnd_al);
         live_ien <= pnd_ien;
         live_msk <= pnd_msk;
      end
   end

   rtc_cal_commit #(.BUSY_CYC(BUSY_CYC)) u_commit (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .trig_i (trig_go),
      .busy_o (busy),
      .done_o (commit_done)
   );

   // ---------------- calendar and alarm ----------------
   logic pwr_en_q, cal_load, cal_run;
   cal_t cal_cur, cal_nxt, snap_q;

   assign cal_load = commit_done && pnd_tm_vld;
   assign cal_run  = tick_i && pwr_en_q && !cal_load;

   rtc_cal_calendar u_cal (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .run_i      (cal_run),
      .load_i     (cal_load),
      .load_val_i (raw2cal(pnd_tm)),
      .cur_o      (cal_cur),
      .nxt_o      (cal_nxt)
   );

   logic al_status, al_pend;

   rtc_cal_alarm u_alarm (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .run_i       (cal_run),
      .en_i        (live_ien),
      .dow_mask_i  (live_msk),
      .alarm_i     (live_al),
      .nxt_i       (cal_nxt),
      .rst_alarm_i (do_rst_alarm),
      .clr_pend_i  (do_clr),
      .status_o    (al_status),
      .pend_o      (al_pend)
   );

   assign irq_o = al_status;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pwr_en_q <= 1'b1;
         snap_q   <= CAL_RST;
      end else begin
         if (ctrl_ok)   pwr_en_q <= wdata_i[B_PWR];
         if (do_reload) snap_q   <= cal_cur;
      end
   end

   // ---------------- read port ----------------
   logic [15:0] rd_val;

   always_comb begin
      rd_val = '0;
      if (is_ctrl) begin
         rd_val[B_PWR]  = pwr_en_q;
         rd_val[B_BUSY] = busy;
      end
      if (addr_i == ADDR_W'(A_STA)) rd_val[B_ALARM]  = al_status;
      if (is_ien)                   rd_val[B_ALARM]  = live_ien;
      if (is_msk)                   rd_val[B_DOWMSK] = live_msk;
      if (addr_i == ADDR_W'(A_PDN)) rd_val[B_PEND]   = al_pend;
      if (tm_sel) rd_val[RAW_W-1:0] = cal_fld(snap_q, tm_idx);
      if (al_sel) rd_val[RAW_W-1:0] = cal_fld(live_al, al_idx);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      rdata_o <= '0;
      else if (rd_en_i) rdata_o <= rd_val;
   end

   logic unused_bits;
   assign unused_bits = ^{wdata_i, tm_off[0], al_off[0]};

   // R6
   key_guard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i && is_ctrl && wdata_i[15:8] != UNLOCK_KEY |=> pwr_en_q == $past(pwr_en_q));

   // R5
   snap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr_en_i && is_ctrl && wdata_i[15:8] == UNLOCK_KEY && wdata_i[B_RELOAD]) |=> $stable(snap_q));

   // R2
   live_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !commit_done |=> $stable(live_ien) && $stable(live_msk) && $stable(live_al));

   // R4
   trig_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy && wr_en_i && is_trg |=> $stable(pnd_tm) && $stable(pnd_al));

endmodule

// File: tb/test_rtc_cal_core.sv
`timescale 1ns/1ps
module test_rtc_cal_core;

   localparam int BUSY = 8;
   localparam logic [7:0] CTRL = 8'h08, STA = 8'h0A, IEN = 8'h0C, MSK = 8'h10;
   localparam logic [7:0] TC = 8'h12, AL = 8'h20, PDN = 8'h36, TRG = 8'h42;

   logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr = 1'b0, rd = 1'b0;
   logic [7:0]  addr  = '0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic        irq;
   int n_chk = 0, n_fail = 0;
   bit done = 0;

   typedef struct {
      logic [7:0]  a;
      logic [15:0] v;
      string       tag;
   } exp_t;
   exp_t q[$];
   logic rd_d = 1'b0;

   always #2.5 clk = ~clk;

   rtc_cal_core #(.ADDR_W(8), .BUSY_CYC(BUSY)) i_rtc_cal_core (
      .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr), .rd_en_i(rd),
      .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq));

   // monitor: compares each registered read against the scoreboard queue
   always @(posedge clk) rd_d <= rd;
   always @(negedge clk) begin
      if (rd_d) begin
         n_chk++;
         if (q.size() == 0) begin
            n_fail++;
            $display("FAIL monitor: read with no expectation, actual %h", rdata);
         end else begin
            exp_t e;
            e = q.pop_front();
            if (rdata !== e.v) begin
               n_fail++;
               $display("FAIL %s addr %h: actual %h expected %h", e.tag, e.a, rdata, e.v);
            end
         end
      end
   end

   task automatic wr_reg(input logic [7:0] a, input logic [15:0] d);
      wr = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic rd_chk(input logic [7:0] a, input logic [15:0] v, input string tag);
      rd = 1'b1; addr = a;
      q.push_back('{a, v, tag});
      @(negedge clk);
      rd = 1'b0;
   endtask

   task automatic ticks(input int n);
      repeat (n) begin
         tick = 1'b1;
         @(negedge clk);
         tick = 1'b0;
      end
   endtask

   task automatic pin_chk(input logic got, input logic exp, input string tag);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s irq_o: actual %b expected %b", tag, got, exp);
      end
   endtask

   task automatic stage(input logic [7:0] base, input int s, m, h, d, w, mo, y);
      wr_reg(base,      16'(s));
      wr_reg(base + 2,  16'(m));
      wr_reg(base + 4,  16'(h));
      wr_reg(base + 6,  16'(d));
      wr_reg(base + 8,  16'(w));
      wr_reg(base + 10, 16'(mo));
      wr_reg(base + 12, 16'(y));
   endtask

   task automatic commit();
      wr_reg(TRG, 16'h0001);
      repeat (BUSY + 2) @(negedge clk);
   endtask

   task automatic set_time(input int s, m, h, d, w, mo, y);
      stage(TC, s, m, h, d, w, mo, y);
      commit();
   endtask

   task automatic chk_time(input int s, m, h, d, w, mo, y, input string tag);
      wr_reg(CTRL, 16'h4321);
      rd_chk(TC,      16'(s),  tag);
      rd_chk(TC + 2,  16'(m),  tag);
      rd_chk(TC + 4,  16'(h),  tag);
      rd_chk(TC + 6,  16'(d),  tag);
      rd_chk(TC + 8,  16'(w),  tag);
      rd_chk(TC + 10, 16'(mo), tag);
      rd_chk(TC + 12, 16'(y),  tag);
   endtask

   task automatic chk_sec(input int s, input string tag);
      wr_reg(CTRL, 16'h4321);
      rd_chk(TC, 16'(s), tag);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin : watchdog
      #(200000 * 5);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd_chk(TC,      16'd0, "R1");
      rd_chk(TC + 2,  16'd0, "R1");
      rd_chk(TC + 4,  16'd0, "R1");
      rd_chk(TC + 6,  16'd1, "R1");
      rd_chk(TC + 8,  16'd1, "R1");
      rd_chk(TC + 10, 16'd1, "R1");
      rd_chk(TC + 12, 16'd0, "R1");
      rd_chk(CTRL, 16'h0001, "R1");
      rd_chk(STA,  16'h0000, "R1");
      pin_chk(irq, 1'b0, "R1");

      // R6 key guard and power enable; R5 reload
      ticks(3);
      chk_sec(3, "R5");
      wr_reg(CTRL, 16'h1220);            // wrong key: no reload, power stays on
      rd_chk(TC, 16'd3, "R6");
      ticks(2);
      chk_sec(5, "R6");
      wr_reg(CTRL, 16'h4300);            // power off
      rd_chk(CTRL, 16'h0000, "R6");
      ticks(2);
      wr_reg(CTRL, 16'h4320);
      rd_chk(TC, 16'd5, "R6");
      wr_reg(CTRL, 16'h4301);

      // R2 staged time write has no effect without a trigger
      wr_reg(TC, 16'd40);
      chk_sec(5, "R2");
      // R3 trigger with bit 0 clear is ignored
      wr_reg(TC, 16'd30);
      wr_reg(TRG, 16'h0000);
      rd_chk(CTRL, 16'h0001, "R3");
      repeat (BUSY + 2) @(negedge clk);
      chk_sec(5, "R3");

      // R3 busy flag and deferred commit
      stage(TC, 58, 59, 23, 28, 7, 2, 4);
      wr_reg(TRG, 16'h0001);
      rd_chk(CTRL, 16'h0041, "R3");
      chk_sec(5, "R3");
      repeat (BUSY + 2) @(negedge clk);
      rd_chk(CTRL, 16'h0001, "R3");
      chk_time(58, 59, 23, 28, 7, 2, 4, "R3");

      // R7 R8 leap February, dow 7 -> 1
      ticks(2);
      chk_time(0, 0, 0, 29, 1, 2, 4, "R8");
      set_time(59, 59, 23, 29, 1, 2, 4);
      ticks(1);
      chk_time(0, 0, 0, 1, 2, 3, 4, "R8");
      set_time(59, 59, 23, 28, 3, 2, 5);
      ticks(1);
      chk_time(0, 0, 0, 1, 4, 3, 5, "R8");
      set_time(59, 59, 23, 31, 3, 12, 127);
      ticks(1);
      chk_time(0, 0, 0, 1, 4, 1, 0, "R8");
      set_time(59, 59, 23, 30, 6, 4, 9);
      ticks(1);
      chk_time(0, 0, 0, 1, 7, 5, 9, "R8");
      set_time(59, 59, 10, 3, 2, 7, 9);
      ticks(1);
      chk_time(0, 0, 11, 3, 2, 7, 9, "R7");

      // R4 writes made during busy wait for the next trigger
      stage(TC, 10, 2, 1, 5, 2, 4, 20);
      wr_reg(TRG, 16'h0001);
      wr_reg(TC, 16'd20);
      repeat (BUSY + 2) @(negedge clk);
      chk_time(10, 2, 1, 5, 2, 4, 20, "R4");
      commit();
      chk_sec(20, "R4");

      // R9 alarm fires and holds; R12 reserved enable bits
      stage(AL, 8, 30, 12, 15, 3, 6, 10);
      wr_reg(IEN, 16'h000D);
      wr_reg(MSK, 16'h0000);
      set_time(5, 30, 12, 15, 3, 6, 10);
      rd_chk(IEN, 16'h0001, "R12");
      rd_chk(AL, 16'd8, "R9");
      ticks(2);
      pin_chk(irq, 1'b0, "R9");
      ticks(1);
      pin_chk(irq, 1'b1, "R9");
      rd_chk(STA, 16'h0001, "R9");
      rd_chk(PDN, 16'h0010, "R9");
      ticks(3);
      pin_chk(irq, 1'b1, "R9");

      // R11 reset-alarm and clear
      wr_reg(CTRL, 16'h4309);
      pin_chk(irq, 1'b0, "R11");
      rd_chk(STA, 16'h0000, "R11");
      rd_chk(PDN, 16'h0010, "R11");
      wr_reg(CTRL, 16'h4303);
      rd_chk(PDN, 16'h0000, "R11");

      // R10 day-of-week mask
      wr_reg(AL, 16'd13);
      wr_reg(AL + 8, 16'd5);
      commit();
      ticks(3);
      pin_chk(irq, 1'b0, "R10");
      wr_reg(AL, 16'd16);
      wr_reg(MSK, 16'h0010);
      commit();
      rd_chk(MSK, 16'h0010, "R10");
      ticks(2);
      pin_chk(irq, 1'b1, "R10");
      wr_reg(CTRL, 16'h4309);

      // R12 enable cleared: a match raises nothing
      wr_reg(IEN, 16'h0000);
      wr_reg(AL, 16'd20);
      commit();
      ticks(4);
      pin_chk(irq, 1'b0, "R12");
      rd_chk(STA, 16'h0000, "R12");

      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule